// File: doc/BRIEF.md
# Operand Effective Address Generator

This unit forms the offset of a memory operand from up to three terms: a base register value, an index register value that may be multiplied by 1, 2, 4 or 8, and a constant displacement. Any of the three terms may be left out. From the same register choice it also derives which segment the access uses by default: stack or data. It flags register combinations that the current operand width does not permit.

Two operand widths are supported. In the narrow (16-bit) mode only two registers may act as base and only two as index. The arithmetic is done modulo 2^16, and scaling is not available. In the wide (32-bit) mode any general register may be the base, and any register but the stack pointer may be the index. The arithmetic is done modulo 2^32.

The decoder ahead of this unit has already decided which operand register is scaled. It presents that register as the index and the other one as the base, whatever their order in the source text. The result is registered, so the offset, segment and flag appear one clock after the inputs.

Top module: `eagen_unit`

## Requirements
- R1: With `mode32`=1 and a legal combination, `ea_off` equals base + (index << scale) + disp modulo 2^32. A term whose valid flag is 0 contributes zero.
- R2: With `mode32`=0, only bits [15:0] of the register values and of `disp` take part. The sum wraps modulo 2^16, and `ea_off[31:16]` is 0.
- R3: With `mode32`=0, a valid base other than code 3 (BX) or code 5 (BP) sets `ea_illegal`=1. So does a valid index other than code 6 (SI) or code 7 (DI).
- R4: With `mode32`=0 and a legal combination, a base of code 5 gives `ea_seg`=1 (stack). A base of code 3, or an index with no base, gives `ea_seg`=0 (data).
- R5: With `mode32`=1, every base code 0..7 is legal. `ea_seg`=1 exactly when the base is valid with code 4 (ESP) or code 5 (EBP). Otherwise `ea_seg`=0.
- R6: With `mode32`=1, a valid index with code 4 (ESP) sets `ea_illegal`=1. Index codes 0..3 and 5..7 are legal.
- R7: With both valid flags 0, `ea_off` equals the displacement, reduced to the mode width. In this case `ea_seg`=0 and `ea_illegal`=0.
- R8: Whenever `ea_illegal`=1, `ea_off` is 0 and `ea_seg` is 0.
- R9: The outputs change only at a rising clock edge and reflect the inputs present before that edge. While `rst_n` is low, all outputs are 0.
- R10: The scale code 0..3 multiplies the index by 1, 2, 4 or 8 in wide mode. The base is never scaled. In narrow mode the scale code has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode32 | input | 1 | 1 = 32-bit operand addressing, 0 = 16-bit |
| base_vld | input | 1 | Base register term present |
| base_sel | input | 3 | Base register code (0 AX,1 CX,2 DX,3 BX,4 SP,5 BP,6 SI,7 DI) |
| idx_vld | input | 1 | Index register term present |
| idx_sel | input | 3 | Index register code, same numbering |
| scale | input | 2 | Index scale code: factor 1 << scale |
| disp | input | 32 | Constant displacement (low 16 bits used in 16-bit mode) |
| rf_flat | input | 256 | Register file values, register n at bits [32n+31:32n] |
| ea_off | output | 32 | Registered effective offset |
| ea_seg | output | 1 | Registered default segment: 0 data, 1 stack |
| ea_illegal | output | 1 | Registered illegal-combination flag |

## Verification
The only internal state is the single output register stage, so any fault in the legality decode, the segment choice, the operand lanes or the adder appears at the ports one clock after the offending inputs. A register-select slip shows up as a wrong offset only when the two registers hold different values. For that reason the register file is loaded with distinct values and is varied. A wrong mask or scale shift shows up in the upper half of the offset, or as a power-of-two error in the offset. The bench compares all three outputs against its own model on every clock.

// File: rtl/eagen_pkg.sv
package eagen_pkg;

    // Register codes shared by both operand widths.
    localparam logic [2:0] REG_AX = 3'd0;
    localparam logic [2:0] REG_CX = 3'd1;
    localparam logic [2:0] REG_DX = 3'd2;
    localparam logic [2:0] REG_BX = 3'd3;
    localparam logic [2:0] REG_SP = 3'd4;
    localparam logic [2:0] REG_BP = 3'd5;
    localparam logic [2:0] REG_SI = 3'd6;
    localparam logic [2:0] REG_DI = 3'd7;

    typedef enum logic {
        SEG_DATA  = 1'b0,
        SEG_STACK = 1'b1
    } seg_e;

endpackage

// File: rtl/eagen_legal.sv
module eagen_legal
    import eagen_pkg::*;
#(
    parameter int SELW = 3
) (
    input  logic            mode32,
    input  logic            base_vld,
    input  logic [SELW-1:0] base_sel,
    input  logic            idx_vld,
    input  logic [SELW-1:0] idx_sel,
    output logic            illegal,
    output seg_e            seg
);

    logic bad_base;
    logic bad_idx;
    logic stack_base;

    always_comb begin
        bad_base   = 1'b0;
        bad_idx    = 1'b0;
        stack_base = 1'b0;
        if (mode32) begin
            // Wide mode: any base; stack pointer may not be an index.
            bad_idx    = idx_vld && (idx_sel == REG_SP);
            stack_base = base_vld && ((base_sel == REG_SP) || (base_sel == REG_BP));
        end else begin
            if (base_vld) begin
                unique case (base_sel)
                    REG_BX:  stack_base = 1'b0;
                    REG_BP:  stack_base = 1'b1;
                    default: bad_base   = 1'b1;
                endcase
            end
            if (idx_vld) begin
                unique case (idx_sel)
                    REG_SI, REG_DI: bad_idx = 1'b0;
                    default:        bad_idx = 1'b1;
                endcase
            end
        end
    end

    assign illegal = bad_base | bad_idx;
    assign seg     = (stack_base && !illegal) ? SEG_STACK : SEG_DATA;

endmodule

// File: rtl/eagen_operand.sv
module eagen_operand #(
    parameter int XLEN = 32,
    parameter int NREG = 8,
    parameter int SELW = 3,
    parameter int SCW  = 2
) (
    input  logic [XLEN*NREG-1:0] rf_flat,
    input  logic [SELW-1:0]      sel,
    input  logic                 vld,
    input  logic                 mode32,
    input  logic [SCW-1:0]       shamt,
    output logic [XLEN-1:0]      val
);

    localparam int HALF = XLEN / 2;

    logic [XLEN-1:0] lanes [NREG];
    logic [XLEN-1:0] raw;
    logic [XLEN-1:0] narrowed;

    for (genvar g = 0; g < NREG; g++) begin : g_lane
        assign lanes[g] = rf_flat[g*XLEN +: XLEN];
    end

    assign raw      = lanes[sel];
    assign narrowed = mode32 ? raw : {{HALF{1'b0}}, raw[HALF-1:0]};
    assign val      = vld ? (narrowed << shamt) : '0;

endmodule

// File: rtl/eagen_sum.sv
module eagen_sum #(
    parameter int XLEN = 32
) (
    input  logic            mode32,
    input  logic [XLEN-1:0] base_term,
    input  logic [XLEN-1:0] idx_term,
    input  logic [XLEN-1:0] disp,
    output logic [XLEN-1:0] sum
);

    localparam int HALF = XLEN / 2;

    logic [XLEN-1:0] full;

    assign full = base_term + idx_term + disp;
    assign sum  = mode32 ? full : {{HALF{1'b0}}, full[HALF-1:0]};

endmodule

// File: rtl/eagen_unit.sv
module eagen_unit
    import eagen_pkg::*;
#(
    parameter int XLEN = 32,
    parameter int NREG = 8,
    parameter int SCW  = 2,
    localparam int SELW = $clog2(NREG)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 mode32,
    input  logic                 base_vld,
    input  logic [SELW-1:0]      base_sel,
    input  logic                 idx_vld,
    input  logic [SELW-1:0]      idx_sel,
    input  logic [SCW-1:0]       scale,
    input  logic [XLEN-1:0]      disp,
    input  logic [XLEN*NREG-1:0] rf_flat,
    output logic [XLEN-1:0]      ea_off,
    output logic                 ea_seg,
    output logic                 ea_illegal
);

    logic [SCW-1:0]  idx_shamt;
    logic [XLEN-1:0] base_term;
    logic [XLEN-1:0] idx_term;
    logic [XLEN-1:0] sum;
    logic            illegal;
    seg_e            seg;

    // Scaling exists only in wide mode.
    assign idx_shamt = mode32 ? scale : '0;

    eagen_legal #(.SELW(SELW)) u_legal (
        .mode32   (mode32),
        .base_vld (base_vld),
        .base_sel (base_sel),
        .idx_vld  (idx_vld),
        .idx_sel  (idx_sel),
        .illegal  (illegal),
        .seg      (seg)
    );

    eagen_operand #(.XLEN(XLEN), .NREG(NREG), .SELW(SELW), .SCW(SCW)) u_base (
        .rf_flat (rf_flat),
        .sel     (base_sel),
        .vld     (base_vld),
        .mode32  (mode32),
        .shamt   ('0),
        .val     (base_term)
    );

    eagen_operand #(.XLEN(XLEN), .NREG(NREG), .SELW(SELW), .SCW(SCW)) u_index (
        .rf_flat (rf_flat),
        .sel     (idx_sel),
        .vld     (idx_vld),
        .mode32  (mode32),
        .shamt   (idx_shamt),
        .val     (idx_term)
    );

    eagen_sum #(.XLEN(XLEN)) u_sum (
        .mode32    (mode32),
        .base_term (base_term),
        .idx_term  (idx_term),
        .disp      (disp),
        .sum       (sum)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ea_off     <= '0;
            ea_seg     <= SEG_DATA;
            ea_illegal <= 1'b0;
        end else begin
            ea_off     <= illegal ? '0 : sum;
            ea_seg     <= seg;
            ea_illegal <= illegal;
        end
    end

endmodule

// File: rtl/eagen_chk.sv
module eagen_chk #(
    parameter int XLEN = 32,
    parameter int SELW = 3
) (
    input logic            clk,
    input logic            rst_n,
    input logic            mode32,
    input logic            base_vld,
    input logic [SELW-1:0] base_sel,
    input logic            idx_vld,
    input logic [SELW-1:0] idx_sel,
    input logic [XLEN-1:0] disp,
    input logic [XLEN-1:0] ea_off,
    input logic            ea_seg,
    input logic            ea_illegal
);

    localparam int HALF = XLEN / 2;

    a_r3_bad_base16: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode32 && base_vld && base_sel != 3 && base_sel != 5) |=> ea_illegal);

    a_r3_bad_index16: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode32 && idx_vld && idx_sel != 6 && idx_sel != 7) |=> ea_illegal);

    a_r6_sp_index: assert property (@(posedge clk) disable iff (!rst_n)
        (mode32 && idx_vld && idx_sel == 4) |=> ea_illegal);

    a_r5_stack_base32: assert property (@(posedge clk) disable iff (!rst_n)
        (mode32 && base_vld && (base_sel == 4 || base_sel == 5) && !(idx_vld && idx_sel == 4))
        |=> (ea_seg && !ea_illegal));

    a_r4_bp_stack16: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode32 && base_vld && base_sel == 5 && (!idx_vld || idx_sel == 6 || idx_sel == 7))
        |=> (ea_seg && !ea_illegal));

    a_r2_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !mode32 |=> (ea_off[XLEN-1:HALF] == '0));

    a_r7_disp_only32: assert property (@(posedge clk) disable iff (!rst_n)
        (mode32 && !base_vld && !idx_vld) |=> (ea_off == $past(disp) && !ea_seg && !ea_illegal));

    a_r8_illegal_clears: assert property (@(posedge clk) disable iff (!rst_n)
        ea_illegal |-> (ea_off == '0 && !ea_seg));

endmodule

bind eagen_unit eagen_chk #(.XLEN(XLEN), .SELW(SELW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode32     (mode32),
    .base_vld   (base_vld),
    .base_sel   (base_sel),
    .idx_vld    (idx_vld),
    .idx_sel    (idx_sel),
    .disp       (disp),
    .ea_off     (ea_off),
    .ea_seg     (ea_seg),
    .ea_illegal (ea_illegal)
);

// File: tb/eagen_unit_tb_top.sv
`timescale 1ns/100ps
module eagen_unit_tb_top;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         mode32 = 1'b0;
    logic         base_vld = 1'b0;
    logic [2:0]   base_sel = '0;
    logic         idx_vld = 1'b0;
    logic [2:0]   idx_sel = '0;
    logic [1:0]   scale = '0;
    logic [31:0]  disp = '0;
    logic [255:0] rf_flat;
    logic [31:0]  ea_off;
    logic         ea_seg;
    logic         ea_illegal;

    logic [31:0] rf [8];
    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    // Expected values of the previous and current vectors.
    logic [31:0] exp_off = '0;
    logic        exp_seg = 1'b0;
    logic        exp_ill = 1'b0;

    always #2.5 clk = ~clk;

    always_comb begin
        for (int i = 0; i < 8; i++) rf_flat[i*32 +: 32] = rf[i];
    end

    eagen_unit dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode32     (mode32),
        .base_vld   (base_vld),
        .base_sel   (base_sel),
        .idx_vld    (idx_vld),
        .idx_sel    (idx_sel),
        .scale      (scale),
        .disp       (disp),
        .rf_flat    (rf_flat),
        .ea_off     (ea_off),
        .ea_seg     (ea_seg),
        .ea_illegal (ea_illegal)
    );

    // Behavioural model written from the requirements.
    task automatic model(output logic [31:0] off, output logic seg, output logic ill);
        longint acc;
        if (mode32) ill = idx_vld && (idx_sel == 4);
        else ill = (base_vld && !(base_sel == 3 || base_sel == 5)) ||
                   (idx_vld && !(idx_sel == 6 || idx_sel == 7));
        if (ill) begin
            off = 0;
            seg = 0;
        end else begin
            acc = longint'(disp);
            if (base_vld) acc = acc + longint'(rf[base_sel]);
            if (idx_vld) acc = acc + longint'(rf[idx_sel]) * (mode32 ? (longint'(1) << scale) : 1);
            off = mode32 ? acc[31:0] : {16'h0, acc[15:0]};
            seg = base_vld && (mode32 ? (base_sel == 4 || base_sel == 5) : (base_sel == 5));
        end
    endtask

    task automatic compare(input string tag);
        checks++;
        if (ea_off !== exp_off || ea_seg !== exp_seg || ea_illegal !== exp_ill) begin
            errors++;
            $display("FAIL %s: off=%h seg=%b ill=%b expected off=%h seg=%b ill=%b",
                     tag, ea_off, ea_seg, ea_illegal, exp_off, exp_seg, exp_ill);
        end
    endtask

    // Drive one vector just after an edge, confirm the outputs hold, then check after the next edge.
    task automatic apply(input string tag, input bit m, input bit bv, input logic [2:0] bs,
                         input bit iv, input logic [2:0] is, input logic [1:0] sc,
                         input logic [31:0] d);
        mode32 = m; base_vld = bv; base_sel = bs; idx_vld = iv; idx_sel = is;
        scale = sc; disp = d;
        #1;
        compare("R9 hold");
        model(exp_off, exp_seg, exp_ill);
        @(posedge clk);
        #1;
        compare(tag);
    endtask

    function automatic string pick_tag();
        logic [31:0] o; logic s; logic il;
        if (mode32 && idx_vld && idx_sel == 4) return "R6";
        if (!mode32 && ((base_vld && !(base_sel == 3 || base_sel == 5)) ||
                        (idx_vld && !(idx_sel == 6 || idx_sel == 7)))) return "R3";
        if (!base_vld && !idx_vld) return "R7";
        return mode32 ? "R1" : "R2";
    endfunction

    initial begin
        #20000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: run hung, expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 8; i++) rf[i] = 32'h1000_0000 * (i + 1) + 32'h0111 * (i + 3);
        // Reset state (R9)
        repeat (3) @(posedge clk);
        #1;
        mode32 = 1'b1; base_vld = 1'b1; base_sel = 3'd5; disp = 32'hFFFF_FFFF;
        #1;
        compare("R9 reset");
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        model(exp_off, exp_seg, exp_ill);
        compare("R9 first edge");

        // Wide mode arithmetic and scaling (R1, R10)
        apply("R1 base+idx+disp", 1, 1, 3'd3, 1, 3'd6, 2'd0, 32'h0000_0040);
        apply("R10 scale x2", 1, 1, 3'd0, 1, 3'd1, 2'd1, 32'h0);
        apply("R10 scale x8", 1, 1, 3'd2, 1, 3'd7, 2'd3, 32'hFFFF_FFF0);
        apply("R10 base unscaled", 1, 1, 3'd6, 0, 3'd0, 2'd3, 32'h0);
        apply("R1 wrap 2^32", 1, 1, 3'd7, 1, 3'd7, 2'd3, 32'h8000_0000);
        // Wide segment and legality (R5, R6)
        apply("R5 esp base stack", 1, 1, 3'd4, 1, 3'd5, 2'd2, 32'h10);
        apply("R5 ebp base stack", 1, 1, 3'd5, 0, 3'd0, 2'd0, 32'h4);
        apply("R5 eax base data", 1, 1, 3'd0, 1, 3'd5, 2'd1, 32'h4);
        apply("R6 esp index", 1, 1, 3'd3, 1, 3'd4, 2'd0, 32'h4);
        apply("R8 illegal zeroes", 1, 1, 3'd5, 1, 3'd4, 2'd3, 32'h1234);
        // Narrow mode (R2, R3, R4, R10)
        apply("R4 bx data", 0, 1, 3'd3, 1, 3'd6, 2'd0, 32'h0000_FFFE);
        apply("R4 bp stack", 0, 1, 3'd5, 1, 3'd7, 2'd0, 32'h0000_0002);
        apply("R4 index only data", 0, 0, 3'd5, 1, 3'd6, 2'd0, 32'h0000_0010);
        apply("R10 narrow scale ignored", 0, 1, 3'd3, 1, 3'd7, 2'd3, 32'h0);
        apply("R2 upper disp ignored", 0, 1, 3'd5, 0, 3'd0, 2'd0, 32'hABCD_8001);
        apply("R3 ax base", 0, 1, 3'd0, 0, 3'd0, 2'd0, 32'h5);
        apply("R3 sp base", 0, 1, 3'd4, 1, 3'd6, 2'd0, 32'h5);
        apply("R3 bx index", 0, 1, 3'd3, 1, 3'd3, 2'd0, 32'h5);
        // Displacement only (R7)
        apply("R7 disp only wide", 1, 0, 3'd5, 0, 3'd4, 2'd3, 32'hDEAD_BEEF);
        apply("R7 disp only narrow", 0, 0, 3'd0, 0, 3'd0, 2'd1, 32'hDEAD_BEEF);

        // Mixed vectors with varying register contents
        for (int n = 0; n < 400; n++) begin
            for (int i = 0; i < 8; i++) rf[i] = $urandom;
            mode32 = $urandom_range(0, 1);
            base_vld = $urandom_range(0, 1);
            base_sel = 3'($urandom_range(0, 7));
            idx_vld = $urandom_range(0, 1);
            idx_sel = 3'($urandom_range(0, 7));
            apply(pick_tag(), mode32, base_vld, base_sel, idx_vld, idx_sel,
                  2'($urandom_range(0, 3)), $urandom);
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule